// File: doc/BRIEF.md
# Grouped Prescaler Tick Generator

This block turns one reference clock into five count-enable strobes, one for each down-counting timer channel that sits beside it. Two 8-bit prescalers run side by side. The first serves channels 0 and 1, and the second serves channels 2, 3 and 4. Each channel takes the strobe of its group's prescaler and divides it again by a power of two chosen by its own 4-bit code. The tick of a channel therefore repeats every (prescale + 1) × 2^code reference cycles.

Two configuration words control the block. The prescaler word holds both prescale values. The divider word holds the five divider codes. Software reaches both words through a small write/read port. A write to either word sends every prescaler and divider counter back to its starting point. The first tick at the new rate therefore comes one whole period after the write, and no part of an old count is carried over.

Top module: `pwm_tick_gen`

## Requirements
- R1: After reset, the prescaler word reads 0x00000101 and the divider word reads 0x00000000. All five channels then tick every 2 cycles.
- R2: In the prescaler word, bits 7:0 set prescaler A and bits 15:8 set prescaler B. Channels 0 and 1 count from prescaler A. Channels 2, 3 and 4 count from prescaler B. A prescaler emits one strobe every (value + 1) cycles.
- R3: In the divider word, the code of channel n sits at bits 4n+3:4n. That channel ticks every (prescale + 1) × 2^code cycles. Between two strobes of its prescaler, a channel's divider count does not change.
- R4: Codes 0 to 4 give divisors 1, 2, 4, 8 and 16. Every code from 5 to 15 acts as divisor 16.
- R5: A write to either word restarts all prescaler and divider counters. Each channel's first tick after the write then falls exactly one new period (N cycles) after the write edge, and the next falls 2N cycles after it.
- R6: Each tick lasts one cycle. Over any window, a channel with period N gives exactly one tick every N cycles. A channel ticks on every cycle only when N = 1.
- R7: When cfg_wr is high on a clock edge, cfg_sel=0 selects the prescaler word and cfg_sel=1 selects the divider word. cfg_rdata shows the selected word without a clock delay. Only bits 15:0 (prescaler word) or bits 19:0 (divider word) are stored, and all higher bits read as 0. A divider code reads back exactly as written, even when its effective value is clamped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the selected configuration word |
| cfg_sel | input | 1 | Word select: 0 = prescaler word, 1 = divider word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Selected configuration word, zero-extended |
| tick | output | 5 | One-cycle count-enable strobe per channel |

## Verification
The assertions check, on every cycle, the invariants that hold no matter what the configuration is. A write always leaves every counter at zero. No prescaler count goes past its limit, and no divider count goes past its clamped limit. A divider moves only when its group's prescaler strobes, and a tick only ever falls on such a strobe. The unused read bits stay zero. Some behaviours need whole periods to show: the exact tick period of each channel for each prescaler value and divider code, the clamping of large codes, the field positions, and the one-period delay to the first tick after each kind of write. The bench shows these by timing the first and second ticks and counting all ticks over a window.

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int NUM_CH   = 5,
  parameter int GRP_A_CH = 2,
  parameter int PS_W     = 8,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [NUM_CH-1:0] tick
);
  localparam int PSW_W  = 2 * PS_W;
  localparam int DIVW_W = NUM_CH * CODE_W;
  localparam int DCNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [PS_W-1:0]   ps_q   [2];
  logic [PS_W-1:0]   pcnt_q [2];
  logic [1:0]        pstb;
  logic [DIVW_W-1:0] div_q;
  logic [DCNT_W-1:0] dcnt_q [NUM_CH];
  logic [DCNT_W-1:0] dlim   [NUM_CH];

  wire wr_ps  = cfg_wr && !cfg_sel;
  wire wr_div = cfg_wr &&  cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q[0] <= PS_W'(1);
      ps_q[1] <= PS_W'(1);
      div_q   <= '0;
    end else begin
      if (wr_ps) begin
        ps_q[0] <= cfg_wdata[PS_W-1:0];
        ps_q[1] <= cfg_wdata[PSW_W-1:PS_W];
      end
      if (wr_div) div_q <= cfg_wdata[DIVW_W-1:0];
    end
  end

  assign cfg_rdata = cfg_sel ? DATA_W'(div_q) : DATA_W'({ps_q[1], ps_q[0]});

  for (genvar k = 0; k < 2; k++) begin : g_ps
    assign pstb[k] = (pcnt_q[k] == ps_q[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pcnt_q[k] <= '0;
      else if (cfg_wr)    pcnt_q[k] <= '0;
      else if (pstb[k])   pcnt_q[k] <= '0;
      else                pcnt_q[k] <= pcnt_q[k] + 1'b1;
    end

    AST_PS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q[k] <= ps_q[k]); // R2
    AST_PS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> pcnt_q[k] == '0); // R5
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int G = (i < GRP_A_CH) ? 0 : 1;
    logic [CODE_W-1:0] code, eff;

    assign code    = div_q[i*CODE_W +: CODE_W];
    assign eff     = (int'(code) > MAX_CODE) ? CODE_W'(MAX_CODE) : code;
    assign dlim[i] = DCNT_W'((32'd1 << eff) - 32'd1);
    assign tick[i] = pstb[G] && (dcnt_q[i] == dlim[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dcnt_q[i] <= '0;
      else if (cfg_wr)  dcnt_q[i] <= '0;
      else if (pstb[G]) dcnt_q[i] <= (dcnt_q[i] == dlim[i]) ? '0 : dcnt_q[i] + 1'b1;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt_q[i] <= dlim[i]); // R4
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstb[G] && !cfg_wr) |=> $stable(dcnt_q[i])); // R3
    AST_TICK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |-> pstb[G]); // R3
    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> dcnt_q[i] == '0); // R5
  end

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:DIVW_W] == '0); // R7
endmodule

// File: tb/test_pwm_tick_gen.sv
module test_pwm_tick_gen;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [4:0]  tick;
  int tests = 0, fails = 0, cyc = 0;
  int exp_p [5];
  logic [15:0] cur_ps;
  logic [19:0] cur_div;

  always #5 clk = ~clk;

  pwm_tick_gen i_pwm_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick(tick));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ps word {B,A}, divider word {c4,c3,c2,c1,c0}
  localparam logic [35:0] VEC [5] = '{
    {16'h0101, 20'h00000},  // all 2
    {16'h0000, 20'h00000},  // all 1
    {16'h0203, 20'h04321},  // 8,16,24,48,3
    {16'h0401, 20'h294F5},  // 32,32,80,80,20 (codes >4 clamp)
    {16'h00FF, 20'h31404}   // 4096,256,16,2,8
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period(input logic [15:0] ps, input logic [19:0] dv, input int ch);
    int p, c;
    p = (ch < 2) ? int'(ps[7:0]) : int'(ps[15:8]);
    c = int'(dv[4*ch +: 4]);
    if (c > 4) c = 4;
    return (p + 1) << c;
  endfunction

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0;
    if (sel) cur_div = d[19:0]; else cur_ps = d[15:0];
  endtask

  task automatic rd_check(input logic sel, input int exp, input string req);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    check(req, int'(cfg_rdata), exp);
  endtask

  // First sample is the current negedge, counted as cycle 1 after the restart.
  task automatic measure(input string req);
    int first [5], second [5], cnt [5];
    int mx, lim;
    mx = 1;
    for (int i = 0; i < 5; i++) begin
      exp_p[i] = period(cur_ps, cur_div, i);
      if (exp_p[i] > mx) mx = exp_p[i];
      first[i] = 0; second[i] = 0; cnt[i] = 0;
    end
    lim = 2 * mx + 3;
    for (int c = 1; c <= lim; c++) begin
      if (c > 1) @(negedge clk);
      for (int i = 0; i < 5; i++) if (tick[i]) begin
        cnt[i]++;
        if (first[i] == 0) first[i] = c;
        else if (second[i] == 0) second[i] = c;
      end
    end
    for (int i = 0; i < 5; i++) begin
      check({req, " R5 first tick"}, first[i], exp_p[i]);
      check({req, " R3 second tick"}, second[i], 2 * exp_p[i]);
      check({req, " R6 tick count"}, cnt[i], lim / exp_p[i]);
    end
  endtask

  initial begin
    cur_ps = 16'h0101; cur_div = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    measure("R1 reset periods");
    rd_check(0, 32'h0101, "R1 ps word reset");
    rd_check(1, 0, "R1 div word reset");

    for (int v = 0; v < 5; v++) begin
      wr(0, {16'h0, VEC[v][35:20]});
      wr(1, {12'h0, VEC[v][19:0]});
      measure($sformatf("R2 R3 R4 vec%0d", v));
    end

    wr(0, 32'h0000_0303);
    wr(1, 32'h0004_4444);
    repeat (20) @(negedge clk);
    wr(1, 32'h0004_4444);
    measure("R5 div-word restart");
    rd_check(0, 32'h0303, "R7 ps word kept");
    repeat (10) @(negedge clk);
    wr(0, 32'h0000_0303);
    measure("R5 ps-word restart");

    wr(0, 32'hFFFF_FFFF);
    rd_check(0, 32'h0000_FFFF, "R7 ps word mask");
    wr(1, 32'hFFFF_FFFF);
    rd_check(1, 32'h000F_FFFF, "R7 div word mask");
    wr(1, 32'h0009_A5F6);
    rd_check(1, 32'h0009_A5F6, "R7 raw code readback");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule